// File: doc/BRIEF.md
# Terminated Recursive Systematic Convolutional Encoder

This block is one constituent of a rate-1/3 parallel concatenated encoder. It is a 16-state, rate-1/2 recursive systematic convolutional coder with constraint length 5. Its feedback generator is 35 octal and its feedforward generator is 23 octal. For every information bit it accepts, it emits the systematic bit and one parity bit. A frame has a fixed number of bit slots. A single-cycle frame start pulse opens a frame and clears the trellis register. A done flag travels with the output of the final slot.

With the `TERMINATE` parameter set, the last five slots of every frame are tail slots. The encoder generates these itself, one per clock, and needs no input strobe. In each tail slot the encoder input is forced to equal the feedback sum, so zeros shift into the register and the trellis ends in state zero. With `TERMINATE` clear, every slot carries user data and the trellis is left open. That mode is used for the encoder placed after the interleaver.

Top module: `rsc_term_encoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `sys_out`, `par_out` and `frame_done` are 0 and `state_out` is 0.
- R2: A `frame_start` pulse clears `state_out` to 0 on the next cycle and restarts the slot count at the first slot. A `bit_valid` in the same cycle is dropped: no output follows it.
- R3: Each consumed slot produces exactly one output one cycle later, with `out_valid`=1. For an information slot `sys_out` equals the accepted `bit_in`. When `out_valid` is 0, both `sys_out` and `par_out` are 0.
- R4: Let the state bits be s1..s4, with s1 = `state_out[0]` the most recent. The slot input is u. The feedback is f = s1^s2^s4, and the recursive bit is a = u^f. Then `par_out` = a^s3^s4, and the next state is {s3,s2,s1,a} written as `state_out[3:0]`.
- R5: In an information slot a cycle with `bit_valid`=0 produces no output and leaves `state_out` unchanged.
- R6: With `TERMINATE`=1 a 256-slot frame holds 251 information slots followed by 5 tail slots. The tail slots are emitted on consecutive cycles regardless of `bit_valid`. In each tail slot `sys_out` equals f, which makes a = 0.
- R7: `frame_done` is 1 exactly with the output of slot 256. With `TERMINATE`=1, `state_out` is 0 in that cycle.
- R8: `bit_valid` and `bit_in` have no effect during tail slots, or after the final slot until the next `frame_start`.
- R9: With `TERMINATE`=0 all 256 slots take input bits on `bit_valid`, and the final state is not forced to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Single-cycle pulse that opens a frame |
| bit_valid | input | 1 | Strobe for an information bit |
| bit_in | input | 1 | Information bit |
| out_valid | output | 1 | An encoded slot is presented |
| sys_out | output | 1 | Systematic bit |
| par_out | output | 1 | Parity bit |
| frame_done | output | 1 | Output belongs to the final slot of the frame |
| state_out | output | 4 | Trellis register, bit 0 most recent |

## Verification
The assertions assume that reset is applied before the first frame and that `frame_start` is a pulse that may arrive at any time, including in the middle of a frame. Beyond that they accept any `bit_valid` and `bit_in` pattern, because the block ignores these inputs whenever they are not wanted. The stimulus changes inputs only away from the clock edge. It drives one shared input stream into a terminated instance and an open instance. Continuous, gapped, all-ones and restarted frames therefore exercise tail slots in one instance while the other is still consuming bits.

// File: rtl/rsc_enc_pkg.sv
package rsc_enc_pkg;

    // Constraint length and derived register width
    localparam int ENC_K   = 5;
    localparam int STATE_W = ENC_K - 1;

    typedef logic [ENC_K-1:0]   poly_t;
    typedef logic [STATE_W-1:0] state_t;

    // Generators, MSB is the D^0 coefficient
    localparam poly_t FB_POLY_DEF = 5'o35;
    localparam poly_t FF_POLY_DEF = 5'o23;

    localparam int FRAME_LEN_DEF = 256;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_INFO,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic valid;
        logic sys;
        logic par;
        logic last;
    } enc_out_t;

    // Map a generator onto the state bits: state bit i holds D^(i+1)
    function automatic state_t tap_mask(poly_t poly);
        state_t m;
        for (int i = 0; i < STATE_W; i++) begin
            m[i] = poly[ENC_K-2-i];
        end
        return m;
    endfunction

endpackage

// File: rtl/rsc_slot_ctrl.sv
module rsc_slot_ctrl
    import rsc_enc_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_LEN_DEF,
    parameter int TAIL_LEN  = ENC_K
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic bit_valid,
    output logic fire,
    output logic in_tail,
    output logic last_slot
);

    localparam int SW       = $clog2(FRAME_LEN);
    localparam int INFO_LEN = FRAME_LEN - TAIL_LEN;
    localparam logic [SW-1:0] LAST_IDX = SW'(FRAME_LEN - 1);
    localparam logic [SW-1:0] INFO_END = SW'(INFO_LEN - 1);

    phase_e        phase;
    logic [SW-1:0] slot;

    always_comb begin
        in_tail   = (phase == PH_TAIL);
        last_slot = (slot == LAST_IDX);
        fire      = !frame_start &&
                    ((phase == PH_TAIL) || ((phase == PH_INFO) && bit_valid));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            slot  <= '0;
        end else if (frame_start) begin
            phase <= PH_INFO;
            slot  <= '0;
        end else if (fire) begin
            if (last_slot) begin
                phase <= PH_IDLE;
                slot  <= '0;
            end else begin
                slot <= slot + 1'b1;
                if ((TAIL_LEN > 0) && (slot == INFO_END)) begin
                    phase <= PH_TAIL;
                end
            end
        end
    end

endmodule

// File: rtl/rsc_trellis.sv
module rsc_trellis
    import rsc_enc_pkg::*;
#(
    parameter poly_t FB_POLY = FB_POLY_DEF,
    parameter poly_t FF_POLY = FF_POLY_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   fire,
    input  logic   in_tail,
    input  logic   bit_in,
    output state_t state,
    output logic   sys_bit,
    output logic   par_bit
);

    localparam state_t FB_MASK = tap_mask(FB_POLY);
    localparam state_t FF_MASK = tap_mask(FF_POLY);
    localparam logic   FF_D0   = FF_POLY[ENC_K-1];

    logic fb_sum;
    logic rec_bit;

    always_comb begin
        fb_sum  = ^(state & FB_MASK);
        // Tail slot: input mirrors feedback so the register fills with zeros
        sys_bit = in_tail ? fb_sum : bit_in;
        rec_bit = sys_bit ^ fb_sum;
        par_bit = (FF_D0 & rec_bit) ^ (^(state & FF_MASK));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state <= '0;
        end else if (fire) begin
            state <= {state[STATE_W-2:0], rec_bit};
        end
    end

endmodule

// File: rtl/rsc_out_stage.sv
module rsc_out_stage
    import rsc_enc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    input  logic     sys_bit,
    input  logic     par_bit,
    input  logic     last_slot,
    output enc_out_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= fire;
            q.sys   <= fire & sys_bit;
            q.par   <= fire & par_bit;
            q.last  <= fire & last_slot;
        end
    end

endmodule

// File: rtl/rsc_term_encoder.sv
module rsc_term_encoder
    import rsc_enc_pkg::*;
#(
    parameter int    FRAME_LEN = FRAME_LEN_DEF,
    parameter bit    TERMINATE = 1'b1,
    parameter poly_t FB_POLY   = FB_POLY_DEF,
    parameter poly_t FF_POLY   = FF_POLY_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               bit_valid,
    input  logic               bit_in,
    output logic               out_valid,
    output logic               sys_out,
    output logic               par_out,
    output logic               frame_done,
    output logic [STATE_W-1:0] state_out
);

    localparam int TAIL_LEN = TERMINATE ? ENC_K : 0;

    logic     fire;
    logic     in_tail;
    logic     last_slot;
    logic     sys_bit;
    logic     par_bit;
    state_t   state;
    enc_out_t oreg;

    rsc_slot_ctrl #(
        .FRAME_LEN (FRAME_LEN),
        .TAIL_LEN  (TAIL_LEN)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .bit_valid   (bit_valid),
        .fire        (fire),
        .in_tail     (in_tail),
        .last_slot   (last_slot)
    );

    rsc_trellis #(
        .FB_POLY (FB_POLY),
        .FF_POLY (FF_POLY)
    ) u_trellis (
        .clk     (clk),
        .rst     (rst),
        .clear   (frame_start),
        .fire    (fire),
        .in_tail (in_tail),
        .bit_in  (bit_in),
        .state   (state),
        .sys_bit (sys_bit),
        .par_bit (par_bit)
    );

    rsc_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .sys_bit   (sys_bit),
        .par_bit   (par_bit),
        .last_slot (last_slot),
        .q         (oreg)
    );

    assign out_valid  = oreg.valid;
    assign sys_out    = oreg.sys;
    assign par_out    = oreg.par;
    assign frame_done = oreg.last;
    assign state_out  = state;

endmodule

// File: rtl/rsc_term_encoder_chk.sv
module rsc_term_encoder_chk #(
    parameter bit TERMINATE = 1'b1,
    parameter int SW        = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_start,
    input logic          out_valid,
    input logic          sys_out,
    input logic          par_out,
    input logic          frame_done,
    input logic [SW-1:0] state_out
);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (state_out == '0) && !out_valid); // R2

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !sys_out && !par_out); // R3

    AST_SHIFT_ON_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> state_out[SW-1:1] == $past(state_out[SW-2:0])); // R4

    AST_HOLD_WITHOUT_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !out_valid && !$past(frame_start) |-> $stable(state_out)); // R5

    AST_DONE_HAS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> out_valid); // R7

    AST_SILENT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !out_valid); // R8

    generate
        if (TERMINATE) begin : g_term
            AST_TAIL_REACHES_ZERO: assert property (@(posedge clk) disable iff (rst)
                frame_done |-> (state_out == '0)); // R7
        end
    endgenerate

endmodule

bind rsc_term_encoder rsc_term_encoder_chk #(
    .TERMINATE (TERMINATE),
    .SW        (rsc_enc_pkg::STATE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .out_valid   (out_valid),
    .sys_out     (sys_out),
    .par_out     (par_out),
    .frame_done  (frame_done),
    .state_out   (state_out)
);

// File: tb/rsc_term_encoder_test.sv
module rsc_term_encoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 256;
    localparam int TAILS      = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fs  = 1'b0;
    logic bv  = 1'b0;
    logic bi  = 1'b0;

    logic       o_valid [2];
    logic       o_sys   [2];
    logic       o_par   [2];
    logic       o_done  [2];
    logic [3:0] o_state [2];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Reference model state, index 0 terminated, 1 open
    logic [3:0] m_state [2];
    int         m_slot  [2];
    bit         m_act   [2];
    logic       e_valid [2];
    logic       e_sys   [2];
    logic       e_par   [2];
    logic       e_done  [2];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsc_term_encoder #(.TERMINATE(1'b1)) uut (
        .clk(clk), .rst(rst), .frame_start(fs), .bit_valid(bv), .bit_in(bi),
        .out_valid(o_valid[0]), .sys_out(o_sys[0]), .par_out(o_par[0]),
        .frame_done(o_done[0]), .state_out(o_state[0])
    );

    rsc_term_encoder #(.TERMINATE(1'b0)) uut_open (
        .clk(clk), .rst(rst), .frame_start(fs), .bit_valid(bv), .bit_in(bi),
        .out_valid(o_valid[1]), .sys_out(o_sys[1]), .par_out(o_par[1]),
        .frame_done(o_done[1]), .state_out(o_state[1])
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // R4 / R6 / R9 reference, written from the requirements
    task automatic ref_step(int m);
        int   info;
        bit   tail;
        logic f, u, a;
        info = (m == 0) ? FRAME - TAILS : FRAME;
        e_valid[m] = 0; e_sys[m] = 0; e_par[m] = 0; e_done[m] = 0;
        if (fs) begin
            m_state[m] = '0; m_slot[m] = 0; m_act[m] = 1;
        end else if (m_act[m]) begin
            tail = (m_slot[m] >= info);
            if (tail || bv) begin
                f = m_state[m][0] ^ m_state[m][1] ^ m_state[m][3];
                u = tail ? f : bi;
                a = u ^ f;
                e_valid[m] = 1;
                e_sys[m]   = u;
                e_par[m]   = a ^ m_state[m][2] ^ m_state[m][3];
                e_done[m]  = (m_slot[m] == FRAME - 1);
                m_state[m] = {m_state[m][2:0], a};
                if (m_slot[m] == FRAME - 1) m_act[m] = 0;
                else m_slot[m]++;
            end
        end
    endtask

    task automatic compare(string scen);
        for (int m = 0; m < 2; m++) begin
            string who;
            who = (m == 0) ? {scen, " term"} : {scen, " open R9"};
            check("R5", {who, " out_valid"}, o_valid[m], e_valid[m]);
            check("R3", {who, " sys_out"},   o_sys[m],   e_sys[m]);
            check("R4", {who, " par_out"},   o_par[m],   e_par[m]);
            check("R7", {who, " frame_done"}, o_done[m], e_done[m]);
            check("R4", {who, " state_out"}, o_state[m], m_state[m]);
            if (m == 0 && e_done[0])
                check("R7", {who, " final state zero"}, o_state[0], 0);
        end
    endtask

    task automatic cycle(logic f, logic v, logic b, string scen);
        @(negedge clk);
        fs = f; bv = v; bi = b;
        ref_step(0);
        ref_step(1);
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare(scen);
    endtask

    task automatic t_reset();
        rst = 1'b1; fs = 0; bv = 1; bi = 1;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            check("R1", "reset out_valid", o_valid[m], 0);
            check("R1", "reset sys/par", {o_sys[m], o_par[m]}, 0);
            check("R1", "reset frame_done", o_done[m], 0);
            check("R1", "reset state", o_state[m], 0);
            m_state[m] = '0; m_slot[m] = 0; m_act[m] = 0;
        end
        @(negedge clk);
        rst = 1'b0; bv = 0; bi = 0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        for (int m = 0; m < 2; m++)
            check("R1", "after reset out_valid", o_valid[m], 0);
    endtask

    task automatic run_out(int mode, string scen);
        int i = 0;
        while (m_act[0] || m_act[1]) begin
            case (mode)
                0: cycle(0, 1, next_bit(), scen);
                1: cycle(0, 1'(i % 3 != 0), next_bit(), scen);
                default: cycle(0, 1, 1, scen);
            endcase
            i++;
        end
        cycle(0, 1, 1, {scen, " R8 idle"});
        cycle(0, 0, 0, {scen, " R8 idle"});
    endtask

    task automatic t_stream();
        cycle(1, 0, 0, "R6 stream start");
        run_out(0, "R6 stream");
    endtask

    task automatic t_gaps();
        cycle(1, 0, 0, "R5 gaps start");
        run_out(1, "R5 gaps");
    endtask

    task automatic t_ones();
        cycle(1, 0, 0, "R6 ones start");
        run_out(2, "R6 ones");
    endtask

    task automatic t_restart();
        cycle(1, 0, 0, "R2 restart open");
        for (int i = 0; i < 40; i++) cycle(0, 1, next_bit(), "R2 before restart");
        cycle(1, 1, 1, "R2 restart pulse");
        check("R2", "state cleared term", o_state[0], 0);
        check("R2", "state cleared open", o_state[1], 0);
        check("R2", "same-cycle bit dropped", o_valid[0], 0);
        run_out(0, "R2 after restart");
    endtask

    task automatic t_idle_ignore();
        for (int i = 0; i < 8; i++) cycle(0, 1, 1'(i & 1), "R8 idle bits");
        check("R8", "term idle state held", o_state[0], m_state[0]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stream();
        t_gaps();
        t_ones();
        t_restart();
        t_idle_ignore();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule